// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates the interrupt requests of a small 8-bit processor core. Five request lines arrive, and they are not all handled the same way:
- one non-maskable line, which needs a rising edge and must still be high when it is sampled;
- one edge-captured line, where a short pulse is remembered;
- two level-held maskable lines;
- one general line, which needs an external acknowledge cycle.

The core issues a sample strobe at each instruction boundary. When any request is active at that strobe, the block accepts the highest-priority one. It then presents that source's fixed vector address and clears the global enable. For the general line, it drives an active-low acknowledge during the T2 state of the acknowledge machine cycle that follows.

Software controls the block through three commands:
- an enable command, which sets the global enable;
- a disable command, which clears it;
- a mask write, which sets or clears the per-source masks and can also discard a captured edge.

The processor datapath, the instruction decode and the fetch of the opcode supplied by the peripheral sit outside this block.

Top module: `pvic_top`

## Requirements
- R1: After reset, `pending` is 0, `take` is 0, `ack_n` is 1 and `vec` is 0. After reset the global enable is 0, all three mask bits are set and both captured requests are cleared, so raising a maskable line together with an enable command leaves `pending` at 0.
- R2: Fixed priority, from highest to lowest, is: `nmi_pin`, `edge_pin`, `lvl_hi_pin`, `lvl_lo_pin`, `gen_pin`. When several requests are active at a strobe, only the highest is accepted.
- R3: Vectors are 0x0024 for the non-maskable source, 0x003C for the edge source, 0x0034 for the high level source, 0x002C for the low level source and 0x0000 for the general source. The opcode for the general source comes from the peripheral.
- R4: The non-maskable source is accepted whatever the enable and mask state. It is active only after a 0-to-1 transition of `nmi_pin`, and only while the pin is still high. If the pin drops before the strobe, the request is lost.
- R5: A rising edge on `edge_pin` is captured even when the line is masked or the enable is off, and a pulse one cycle long is enough. The captured request stays until that source is accepted, and acceptance clears it.
- R6: A mask write with `mask_wdata[3]`=1 clears the captured edge request.
- R7: `mask_wdata` bits [2], [1] and [0] mask the edge, high level and low level sources; 1 means masked. A level source is active only while its pin is 1, the enable is 1 and its mask bit is 0. The general source needs its pin high and the enable set.
- R8: Acceptance happens only at a clock edge where `sample_stb` is 1 and some request is active. `take` is high for the one following cycle, and `vec` holds the accepted vector from then on.
- R9: Acceptance clears the global enable. A disable command clears it, and an enable command sets it. When both commands arrive in the same cycle, disable wins.
- R10: After the general source is accepted, `ack_n` is 0 in exactly the next cycle where `t2_in` is 1, and is 1 at all other times.
- R11: `pending` is 1 exactly when at least one source is active, as defined in R4, R5 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_pin | input | 1 | Non-maskable request |
| edge_pin | input | 1 | Edge-captured request |
| lvl_hi_pin | input | 1 | Level request, higher of the two |
| lvl_lo_pin | input | 1 | Level request, lower of the two |
| gen_pin | input | 1 | General request, needs acknowledge |
| sample_stb | input | 1 | Instruction-boundary sample strobe |
| en_cmd | input | 1 | Set global enable |
| dis_cmd | input | 1 | Clear global enable |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 4 | [3] clear edge capture, [2:0] masks edge/hi/lo |
| t2_in | input | 1 | T2 state of the acknowledge cycle |
| pending | output | 1 | Some request is active |
| take | output | 1 | One-cycle acceptance pulse |
| vec | output | ADDR_W | Vector of the last accepted source |
| ack_n | output | 1 | Active-low acknowledge for the general source |

## Verification
The bench builds the block with its default 16-bit vector width, where every vector value is visible in full. Five request lines give a request space of only 32 combinations, so the bench sweeps all of them and checks, for each, the accepted vector against a priority rule it computes itself. It also sweeps all eight mask settings with every maskable line raised. Directed sequences then cover the edge-capture memory, a non-maskable pulse that ends before the strobe, and simultaneous enable and disable commands.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_EDGE = 3'd2,
        SRC_HI   = 3'd3,
        SRC_LO   = 3'd4,
        SRC_GEN  = 3'd5
    } src_e;

    localparam int NSRC    = 5;
    localparam int MASK_W  = 3;
    localparam int VEC_W   = 16;

    // highest priority in the most significant bit
    typedef struct packed {
        logic nmi;
        logic edg;
        logic hi;
        logic lo;
        logic gen;
    } req_t;

    // restart numbers are counted in halves: vector = halves * 4
    function automatic logic [VEC_W-1:0] vec_of(input src_e s);
        logic [VEC_W-1:0] halves;
        case (s)
            SRC_NMI:  halves = 16'd9;
            SRC_EDGE: halves = 16'd15;
            SRC_HI:   halves = 16'd13;
            SRC_LO:   halves = 16'd11;
            default:  halves = 16'd0;
        endcase
        return halves << 2;
    endfunction

endpackage

// File: rtl/pvic_edge_latch.sv
module pvic_edge_latch #(
    parameter bit NEED_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic clr,
    output logic q
);
    logic prev_q;
    logic hold_q;
    logic rise;

    assign rise = pin & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin;
    end

    generate
        if (NEED_LEVEL) begin : g_level
            // request dies as soon as the line drops
            always_ff @(posedge clk) begin
                if (rst) hold_q <= 1'b0;
                else     hold_q <= pin & (hold_q | rise) & ~clr;
            end
            assign q = hold_q & pin;
        end else begin : g_pulse
            always_ff @(posedge clk) begin
                if (rst) hold_q <= 1'b0;
                else     hold_q <= (hold_q | rise) & ~clr;
            end
            assign q = hold_q;
        end
    endgenerate
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
    import pvic_pkg::*;
(
    input  req_t            req,
    output src_e            win,
    output logic [NSRC-1:0] grant
);
    logic [NSRC-1:0] rv;
    logic [NSRC-1:0] higher;

    assign rv = req;

    // grant bit i only when no higher bit is set
    generate
        for (genvar i = NSRC - 1; i >= 0; i--) begin : g_chain
            if (i == NSRC - 1) begin : g_top
                assign higher[i] = 1'b0;
            end else begin : g_rest
                assign higher[i] = higher[i+1] | rv[i+1];
            end
            assign grant[i] = rv[i] & ~higher[i];
        end
    endgenerate

    always_comb begin
        unique case (1'b1)
            grant[4]: win = SRC_NMI;
            grant[3]: win = SRC_EDGE;
            grant[2]: win = SRC_HI;
            grant[1]: win = SRC_LO;
            grant[0]: win = SRC_GEN;
            default:  win = SRC_NONE;
        endcase
    end
endmodule

// File: rtl/pvic_ack_seq.sv
module pvic_ack_seq (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic t2_in,
    output logic ack_n,
    output logic busy
);
    logic act_q;

    always_ff @(posedge clk) begin
        if (rst)        act_q <= 1'b0;
        else if (start) act_q <= 1'b1;
        else if (t2_in) act_q <= 1'b0;
    end

    assign busy  = act_q;
    assign ack_n = ~(act_q & t2_in);
endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_pin,
    input  logic              edge_pin,
    input  logic              lvl_hi_pin,
    input  logic              lvl_lo_pin,
    input  logic              gen_pin,
    input  logic              sample_stb,
    input  logic              en_cmd,
    input  logic              dis_cmd,
    input  logic              mask_wr,
    input  logic [3:0]        mask_wdata,
    input  logic              t2_in,
    output logic              pending,
    output logic              take,
    output logic [ADDR_W-1:0] vec,
    output logic              ack_n
);
    localparam int CLR_BIT = MASK_W;

    logic              ie_q;
    logic [MASK_W-1:0] mask_q;
    logic              nmi_req;
    logic              edge_held;
    logic              accept;
    logic              clr_nmi;
    logic              clr_edge;
    logic              ack_busy;
    logic              take_q;
    logic [ADDR_W-1:0] vec_q;
    req_t              req;
    src_e              win;
    logic [NSRC-1:0]   grant;

    pvic_edge_latch #(.NEED_LEVEL(1'b1)) u_nmi (
        .clk(clk), .rst(rst), .pin(nmi_pin), .clr(clr_nmi), .q(nmi_req)
    );

    pvic_edge_latch #(.NEED_LEVEL(1'b0)) u_edge (
        .clk(clk), .rst(rst), .pin(edge_pin), .clr(clr_edge), .q(edge_held)
    );

    always_comb begin
        req.nmi = nmi_req;
        req.edg = edge_held  & ie_q & ~mask_q[2];
        req.hi  = lvl_hi_pin & ie_q & ~mask_q[1];
        req.lo  = lvl_lo_pin & ie_q & ~mask_q[0];
        req.gen = gen_pin    & ie_q;
    end

    pvic_arbiter u_arb (.req(req), .win(win), .grant(grant));

    assign pending  = |req;
    assign accept   = sample_stb & pending;
    assign clr_nmi  = accept & (win == SRC_NMI);
    assign clr_edge = (accept & (win == SRC_EDGE)) | (mask_wr & mask_wdata[CLR_BIT]);

    always_ff @(posedge clk) begin
        if (rst)                   ie_q <= 1'b0;
        else if (accept | dis_cmd) ie_q <= 1'b0;
        else if (en_cmd)           ie_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '1;
        else if (mask_wr) mask_q <= mask_wdata[MASK_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= accept;
            if (accept) vec_q <= ADDR_W'(vec_of(win));
        end
    end

    pvic_ack_seq u_ack (
        .clk(clk), .rst(rst), .start(accept & (win == SRC_GEN)),
        .t2_in(t2_in), .ack_n(ack_n), .busy(ack_busy)
    );

    assign take = take_q;
    assign vec  = vec_q;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_stb,
    input logic              take,
    input logic [ADDR_W-1:0] vec,
    input logic              ack_n,
    input logic              t2_in,
    input logic              ie,
    input logic              nmi_pin,
    input logic              dis_cmd,
    input logic [4:0]        grant,
    input logic [2:0]        mask
);
    // R8: acceptance pulse follows a strobe
    a_r8_take_after_strobe: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(sample_stb));

    // R2: at most one source wins
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R10: acknowledge only during T2
    a_r10_ack_in_t2: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> t2_in);

    // R9: acceptance leaves enable off
    a_r9_ie_off_on_take: assert property (@(posedge clk) disable iff (rst)
        take |-> !ie);

    // R9: disable command clears enable
    a_r9_dis_clears: assert property (@(posedge clk) disable iff (rst)
        $past(dis_cmd) |-> !ie);

    // R7: a masked high level source is never accepted
    a_r7_hi_unmasked: assert property (@(posedge clk) disable iff (rst)
        (take && vec == ADDR_W'(16'h0034)) |-> $past(!mask[1]));

    // R4: non-maskable vector needs the pin high at the strobe
    a_r4_nmi_level: assert property (@(posedge clk) disable iff (rst)
        (take && vec == ADDR_W'(16'h0024)) |-> $past(nmi_pin));
endmodule

bind pvic_top pvic_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .take(take), .vec(vec),
    .ack_n(ack_n), .t2_in(t2_in), .ie(ie_q), .nmi_pin(nmi_pin),
    .dis_cmd(dis_cmd), .grant(grant), .mask(mask_q)
);

// File: tb/sim_pvic_top.sv
module sim_pvic_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_pin = 0, edge_pin = 0, lvl_hi_pin = 0, lvl_lo_pin = 0, gen_pin = 0;
    logic        sample_stb = 0, en_cmd = 0, dis_cmd = 0, mask_wr = 0, t2_in = 0;
    logic [3:0]  mask_wdata = 0;
    logic        pending, take, ack_n;
    logic [15:0] vec;
    int          n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    pvic_top #(.ADDR_W(16)) u0 (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .edge_pin(edge_pin),
        .lvl_hi_pin(lvl_hi_pin), .lvl_lo_pin(lvl_lo_pin), .gen_pin(gen_pin),
        .sample_stb(sample_stb), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .t2_in(t2_in),
        .pending(pending), .take(take), .vec(vec), .ack_n(ack_n)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic pins(input logic [4:0] p);
        {nmi_pin, edge_pin, lvl_hi_pin, lvl_lo_pin, gen_pin} = p;
    endtask

    task automatic do_reset();
        pins(5'b0); rst = 1; step(); step(); rst = 0;
    endtask

    task automatic wr_mask(input logic [3:0] d, input logic en);
        mask_wr = 1; mask_wdata = d; en_cmd = en; step();
        mask_wr = 0; en_cmd = 0;
    endtask

    task automatic strobe(); sample_stb = 1; step(); sample_stb = 0; endtask

    // p: {nmi, edge, hi, lo, gen}, highest priority first
    function automatic int exp_vec(input logic [4:0] p);
        int halves;
        if (p[4])      halves = 9;
        else if (p[3]) halves = 15;
        else if (p[2]) halves = 13;
        else if (p[1]) halves = 11;
        else           halves = 0;
        return halves * 4;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 pending", pending, 0);
        chk("R1 take", take, 0);
        chk("R1 ack_n", ack_n, 1);
        chk("R1 vec", vec, 0);
        en_cmd = 1; step(); en_cmd = 0;
        pins(5'b00110); step();
        chk("R1 masks set", pending, 0);

        // R2 R3 R10 R11: all request patterns
        for (int p = 0; p < 32; p++) begin
            do_reset();
            wr_mask(4'b0000, 1'b1);
            pins(p[4:0]); step();
            chk("R11 pending", pending, (p != 0) ? 1 : 0);
            strobe();
            chk("R8 take", take, (p != 0) ? 1 : 0);
            if (p != 0) chk("R2 R3 vector", vec, exp_vec(p[4:0]));
            if (p == 1) begin
                t2_in = 1; #1;
                chk("R10 ack low in T2", ack_n, 0);
                step(); t2_in = 0; #1;
                chk("R10 ack released", ack_n, 1);
                t2_in = 1; #1;
                chk("R10 single ack", ack_n, 1);
                t2_in = 0;
            end
        end

        // R7: mask sweep with edge, hi, lo raised
        for (int m = 0; m < 8; m++) begin
            do_reset();
            wr_mask(4'(m), 1'b1);
            pins(5'b01110); step();
            strobe();
            chk("R7 masked take", take, (m == 7) ? 0 : 1);
            if (m != 7)
                chk("R7 masked vector", vec,
                    !m[2] ? 60 : (!m[1] ? 52 : 44));
        end

        // R4: non-maskable with enable off and masks set
        do_reset();
        nmi_pin = 1; step();
        chk("R4 nmi pending", pending, 1);
        strobe();
        chk("R4 nmi vector", vec, 36);
        chk("R4 nmi taken", take, 1);
        step();
        chk("R4 nmi cleared", pending, 0);
        // R4: pin dropped before the strobe
        do_reset();
        nmi_pin = 1; step(); nmi_pin = 0; step();
        chk("R4 nmi lost", pending, 0);
        strobe();
        chk("R4 nmi no take", take, 0);

        // R5: short pulse is held, acceptance clears it
        do_reset();
        wr_mask(4'b0000, 1'b1);
        edge_pin = 1; step(); edge_pin = 0; step(); step(); step();
        chk("R5 pulse held", pending, 1);
        strobe();
        chk("R5 edge vector", vec, 60);
        en_cmd = 1; step(); en_cmd = 0;
        chk("R5 cleared on accept", pending, 0);
        // R5: captured while masked, visible after unmask
        do_reset();
        en_cmd = 1; edge_pin = 1; step(); en_cmd = 0; edge_pin = 0; step();
        chk("R5 masked hidden", pending, 0);
        wr_mask(4'b0000, 1'b0);
        chk("R5 unmasked shows", pending, 1);

        // R6: clear bit discards the captured edge
        do_reset();
        wr_mask(4'b0000, 1'b1);
        edge_pin = 1; step(); edge_pin = 0; step();
        wr_mask(4'b1000, 1'b0);
        chk("R6 edge cleared", pending, 0);
        strobe();
        chk("R6 no take", take, 0);

        // R8: no acceptance without strobe
        do_reset();
        wr_mask(4'b0000, 1'b1);
        lvl_hi_pin = 1;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R8 no strobe no take", take, 0);
        end

        // R9: enable and disable commands
        do_reset();
        wr_mask(4'b0000, 1'b0);
        lvl_hi_pin = 1; step();
        chk("R9 off", pending, 0);
        en_cmd = 1; step(); en_cmd = 0;
        chk("R9 enabled", pending, 1);
        dis_cmd = 1; step(); dis_cmd = 0;
        chk("R9 disabled", pending, 0);
        en_cmd = 1; dis_cmd = 1; step(); en_cmd = 0; dis_cmd = 0;
        chk("R9 disable wins", pending, 0);
        en_cmd = 1; step(); en_cmd = 0;
        strobe();
        chk("R9 accepted", take, 1);
        chk("R9 off after accept", pending, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule